// File: doc/BRIEF.md
# Dual-Port X/Y Data Space Front End

This block sits between a 16-bit DSP-style core and its byte-addressed data memory. The memory is one linear space split by a fixed boundary into a lower X region and an upper Y region. Anything above the physical size is unimplemented. Two read ports work at the same time. The X port serves every instruction. It reads words or single bytes. The Y port reads whole words only, and only for the second operand prefetch of multiply-accumulate operations. A separate write bus is the only way into the memory. Accumulator write-back and all ordinary stores use it, and it may target either region.

Each effective address is classified in the cycle it is presented. A read that falls outside the region its pointer is allowed to use returns a zero word. A read of unimplemented memory also returns zero. Both cases raise the invalid flag of that port in the same cycle as the zero data. The X port has a prefetch qualifier. With it set, the X port acts as the X operand pointer of a multiply-accumulate and may not read the Y region. Without it, the X port sees the whole linear space. Both ports return data one clock after the request.

Top module: `ds_xy_front`

## Requirements
- R1: During and right after synchronous reset, both ports hold rvalid, invalid and rdata at 0.
- R2: A request on either port produces rvalid with its data and invalid flag exactly one clock later. An X read and a Y read issued in the same cycle both complete in the next cycle.
- R3: A word read on the X port at an implemented address returns the stored 16-bit word. Address bit 0 is ignored for word accesses.
- R4: A byte read on the X port selects the low byte (bits 7:0) when address bit 0 is 0 and the high byte (bits 15:8) when it is 1. The byte is returned in bits 7:0 and bits 15:8 read as zero.
- R5: A byte write stores wr_data[7:0] into the lane chosen by address bit 0 and leaves the other lane of that word unchanged. A word write stores all 16 bits.
- R6: A write may target any implemented address, in the X region or the Y region. A write to an address at or above MEM_BYTES changes no location.
- R7: A read on either port at an address at or above MEM_BYTES returns 0x0000 with invalid set.
- R8: An X read with x_pref set at an address in [Y_START, MEM_BYTES) returns 0x0000 with invalid set. With x_pref clear, the same address reads normally.
- R9: A Y read at an address below Y_START returns 0x0000 with invalid set. At an address in [Y_START, MEM_BYTES) it returns the whole stored word, ignoring bit 0.
- R10: A read in the same cycle as a write to the same word returns the old contents. The new value is visible from the next cycle.
- R11: In a cycle with no outstanding request, a port shows rvalid 0, invalid 0 and rdata 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_req | input | 1 | X port read request |
| x_pref | input | 1 | X read is a multiply-accumulate operand prefetch (X region only) |
| x_byte | input | 1 | X read is a byte access |
| x_addr | input | 16 | X read byte address |
| x_rvalid | output | 1 | X read result valid |
| x_rdata | output | 16 | X read data |
| x_invalid | output | 1 | X read was illegal; data forced to zero |
| y_req | input | 1 | Y port word read request |
| y_addr | input | 16 | Y read byte address |
| y_rvalid | output | 1 | Y read result valid |
| y_rdata | output | 16 | Y read data |
| y_invalid | output | 1 | Y read was illegal; data forced to zero |
| wr_en | input | 1 | Write strobe (stores and accumulator write-back) |
| wr_byte | input | 1 | Write is a byte access |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |

## Verification
The assertions assume that request and qualifier inputs are stable, 2-state values at each rising edge. They also assume the qualifiers x_pref and x_byte matter only while x_req is high. The properties on returned data cover only results whose value does not depend on memory contents: zero substitution and the cleared high byte of byte reads. So they hold even while locations are still unwritten. The stimulus changes every input only on the falling edge. It reads a location only after the bench has written it, so each expected word follows from the bench's own write history.

// File: rtl/ds_pkg.sv
package ds_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    // How a pointer is allowed to reach the data space
    typedef enum logic [1:0] {
        PTR_LINEAR = 2'd0,   // ordinary access: whole implemented space
        PTR_XPREF  = 2'd1,   // operand prefetch through an X pointer
        PTR_YPREF  = 2'd2    // operand prefetch through a Y pointer
    } ptr_kind_e;

    // Classified effective address
    typedef struct packed {
        logic legal;     // access permitted and backed by memory
        logic hi_byte;   // address bit 0: selects the upper lane
    } ea_t;

    function automatic logic [DATA_W-1:0] lane_pick(
        input logic [DATA_W-1:0] word,
        input logic              hi,
        input logic              byte_op
    );
        if (!byte_op) return word;
        return {{(DATA_W-BYTE_W){1'b0}}, (hi ? word[DATA_W-1:BYTE_W] : word[BYTE_W-1:0])};
    endfunction

endpackage

// File: rtl/ds_ea_decode.sv
module ds_ea_decode
    import ds_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 2048,
    parameter int unsigned Y_START   = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  ptr_kind_e         kind,
    output ea_t               ea
);
    localparam logic [ADDR_W-1:0] MEM_END = ADDR_W'(MEM_BYTES);
    localparam logic [ADDR_W-1:0] Y_LO    = ADDR_W'(Y_START);

    logic backed;
    logic in_y;

    always_comb begin
        backed = (addr < MEM_END);
        in_y   = backed && (addr >= Y_LO);
        ea.hi_byte = addr[0];
        unique case (kind)
            PTR_XPREF: ea.legal = backed && !in_y;
            PTR_YPREF: ea.legal = in_y;
            default:   ea.legal = backed;
        endcase
    end
endmodule

// File: rtl/ds_byte_lane.sv
module ds_byte_lane
    import ds_pkg::*;
#(
    parameter int unsigned WORDS = 1024,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [BYTE_W-1:0] w_data,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [BYTE_W-1:0] a_q,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [BYTE_W-1:0] b_q
);
    logic [BYTE_W-1:0] mem [WORDS];

    // Reads sample the array before this edge's write lands
    always_ff @(posedge clk) begin
        if (we) mem[w_idx] <= w_data;
        a_q <= mem[a_idx];
        b_q <= mem[b_idx];
    end
endmodule

// File: rtl/ds_read_stage.sv
module ds_read_stage
    import ds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              byte_op,
    input  ea_t               ea,
    input  logic [DATA_W-1:0] word_q,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              invalid
);
    logic valid_q, ok_q, hi_q, byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ok_q    <= 1'b0;
            hi_q    <= 1'b0;
            byte_q  <= 1'b0;
        end else begin
            valid_q <= req;
            ok_q    <= req && ea.legal;
            hi_q    <= ea.hi_byte;
            byte_q  <= req && byte_op;
        end
    end

    always_comb begin
        rvalid  = valid_q;
        invalid = valid_q && !ok_q;
        rdata   = (valid_q && ok_q) ? lane_pick(word_q, hi_q, byte_q) : '0;
    end
endmodule

// File: rtl/ds_xy_front.sv
module ds_xy_front
    import ds_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 2048,
    parameter int unsigned Y_START   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x_req,
    input  logic              x_pref,
    input  logic              x_byte,
    input  logic [ADDR_W-1:0] x_addr,
    output logic              x_rvalid,
    output logic [DATA_W-1:0] x_rdata,
    output logic              x_invalid,
    input  logic              y_req,
    input  logic [ADDR_W-1:0] y_addr,
    output logic              y_rvalid,
    output logic [DATA_W-1:0] y_rdata,
    output logic              y_invalid,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned WORDS  = MEM_BYTES / 2;
    localparam int          IDX_W  = $clog2(WORDS);
    localparam int          LANES  = DATA_W / BYTE_W;
    localparam logic [ADDR_W-1:0] MEM_END = ADDR_W'(MEM_BYTES);
    localparam logic [ADDR_W-1:0] Y_LO    = ADDR_W'(Y_START);

    ea_t x_ea, y_ea, w_ea;
    ptr_kind_e x_kind;

    assign x_kind = x_pref ? PTR_XPREF : PTR_LINEAR;

    ds_ea_decode #(.MEM_BYTES(MEM_BYTES), .Y_START(Y_START)) i_dec_x (
        .addr(x_addr), .kind(x_kind), .ea(x_ea));
    ds_ea_decode #(.MEM_BYTES(MEM_BYTES), .Y_START(Y_START)) i_dec_y (
        .addr(y_addr), .kind(PTR_YPREF), .ea(y_ea));
    // write-back sees X and Y as one combined space
    ds_ea_decode #(.MEM_BYTES(MEM_BYTES), .Y_START(Y_START)) i_dec_w (
        .addr(wr_addr), .kind(PTR_LINEAR), .ea(w_ea));

    logic [BYTE_W-1:0] x_lane_q [LANES];
    logic [BYTE_W-1:0] y_lane_q [LANES];
    logic [DATA_W-1:0] x_word_q, y_word_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [0:0] IS_HI = 1'((l % 2) == 1);
        logic              lane_we;
        logic [BYTE_W-1:0] lane_wd;

        assign lane_we = wr_en && w_ea.legal && (!wr_byte || (w_ea.hi_byte == IS_HI));
        assign lane_wd = wr_byte ? wr_data[BYTE_W-1:0] : wr_data[l*BYTE_W +: BYTE_W];

        ds_byte_lane #(.WORDS(WORDS)) i_lane (
            .clk   (clk),
            .we    (lane_we),
            .w_idx (wr_addr[IDX_W:1]),
            .w_data(lane_wd),
            .a_idx (x_addr[IDX_W:1]),
            .a_q   (x_lane_q[l]),
            .b_idx (y_addr[IDX_W:1]),
            .b_q   (y_lane_q[l])
        );

        assign x_word_q[l*BYTE_W +: BYTE_W] = x_lane_q[l];
        assign y_word_q[l*BYTE_W +: BYTE_W] = y_lane_q[l];
    end

    ds_read_stage i_stage_x (
        .clk(clk), .rst(rst), .req(x_req), .byte_op(x_byte), .ea(x_ea),
        .word_q(x_word_q), .rvalid(x_rvalid), .rdata(x_rdata), .invalid(x_invalid));

    // Y port fetches whole words only
    ds_read_stage i_stage_y (
        .clk(clk), .rst(rst), .req(y_req), .byte_op(1'b0), .ea(y_ea),
        .word_q(y_word_q), .rvalid(y_rvalid), .rdata(y_rdata), .invalid(y_invalid));

    AST_X_LATENCY: assert property (@(posedge clk) disable iff (rst)
        x_req |=> x_rvalid); // R2
    AST_Y_LATENCY: assert property (@(posedge clk) disable iff (rst)
        y_req |=> y_rvalid); // R2
    AST_X_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (x_req && x_addr >= MEM_END) |=> (x_invalid && x_rdata == '0)); // R7
    AST_Y_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (y_req && y_addr >= MEM_END) |=> (y_invalid && y_rdata == '0)); // R7
    AST_XPREF_IN_Y: assert property (@(posedge clk) disable iff (rst)
        (x_req && x_pref && x_addr >= Y_LO) |=> (x_invalid && x_rdata == '0)); // R8
    AST_Y_IN_X: assert property (@(posedge clk) disable iff (rst)
        (y_req && y_addr < Y_LO) |=> (y_invalid && y_rdata == '0)); // R9
    AST_BYTE_HI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (x_req && x_byte) |=> (x_rdata[DATA_W-1:BYTE_W] == '0)); // R4
    AST_X_IDLE: assert property (@(posedge clk) disable iff (rst)
        !x_req |=> (!x_rvalid && !x_invalid)); // R11
endmodule

// File: tb/test_ds_xy_front.sv
module test_ds_xy_front;
    logic        clk = 1'b0;
    logic        rst;
    logic        x_req, x_pref, x_byte;
    logic [15:0] x_addr;
    logic        x_rvalid, x_invalid;
    logic [15:0] x_rdata;
    logic        y_req;
    logic [15:0] y_addr;
    logic        y_rvalid, y_invalid;
    logic [15:0] y_rdata;
    logic        wr_en, wr_byte;
    logic [15:0] wr_addr, wr_data;

    int applied = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ds_xy_front #(.MEM_BYTES(2048), .Y_START(1024)) i_ds_xy_front (
        .clk(clk), .rst(rst),
        .x_req(x_req), .x_pref(x_pref), .x_byte(x_byte), .x_addr(x_addr),
        .x_rvalid(x_rvalid), .x_rdata(x_rdata), .x_invalid(x_invalid),
        .y_req(y_req), .y_addr(y_addr),
        .y_rvalid(y_rvalid), .y_rdata(y_rdata), .y_invalid(y_invalid),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_addr(wr_addr), .wr_data(wr_data));

    typedef struct packed {
        logic        on_y;
        logic        pref;
        logic        byt;
        logic [15:0] addr;
        logic [15:0] exp;
        logic        inv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0010, 16'hAB34, 1'b0},  // R3 R5
        '{1'b0, 1'b0, 1'b0, 16'h0011, 16'hAB34, 1'b0},  // R3 bit0 ignored
        '{1'b0, 1'b0, 1'b1, 16'h0010, 16'h0034, 1'b0},  // R4 low
        '{1'b0, 1'b0, 1'b1, 16'h0011, 16'h00AB, 1'b0},  // R4 high
        '{1'b0, 1'b0, 1'b0, 16'h0500, 16'hBEEF, 1'b0},  // R8 linear into Y, R6
        '{1'b0, 1'b1, 1'b0, 16'h0500, 16'h0000, 1'b1},  // R8
        '{1'b0, 1'b1, 1'b0, 16'h0010, 16'hAB34, 1'b0},  // R8 legal prefetch
        '{1'b0, 1'b0, 1'b0, 16'h0800, 16'h0000, 1'b1},  // R7
        '{1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b1},  // R7
        '{1'b0, 1'b0, 1'b0, 16'h0100, 16'h7777, 1'b0},  // R6 no alias write
        '{1'b0, 1'b0, 1'b0, 16'h0502, 16'h005A, 1'b0},  // R5
        '{1'b0, 1'b0, 1'b1, 16'h0503, 16'h0000, 1'b0},  // R5 other lane kept
        '{1'b1, 1'b0, 1'b0, 16'h0500, 16'hBEEF, 1'b0},  // R9
        '{1'b1, 1'b0, 1'b0, 16'h0010, 16'h0000, 1'b1},  // R9
        '{1'b1, 1'b0, 1'b0, 16'h0800, 16'h0000, 1'b1},  // R7
        '{1'b1, 1'b0, 1'b0, 16'h0501, 16'hBEEF, 1'b0}   // R9 whole word
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        x_req = 0; x_pref = 0; x_byte = 0; x_addr = '0;
        y_req = 0; y_addr = '0;
        wr_en = 0; wr_byte = 0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic write(input logic [15:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        wr_en = 1; wr_byte = b; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_byte = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 x", {13'b0, x_rvalid, x_invalid, 1'b0} | x_rdata, 16'h0000);
        check("R1 y", {13'b0, y_rvalid, y_invalid, 1'b0} | y_rdata, 16'h0000);
        rst = 0;
        @(negedge clk);
        check("R11 idle", {14'b0, x_rvalid, y_invalid} | x_rdata, 16'h0000);

        write(16'h0010, 16'h1234, 1'b0);
        write(16'h0011, 16'h00AB, 1'b1);   // R5 high lane
        write(16'h0500, 16'hBEEF, 1'b0);   // R6 Y region write
        write(16'h0502, 16'h0000, 1'b0);
        write(16'h0502, 16'hFF5A, 1'b1);   // R5 low lane, bits 15:8 unused
        write(16'h0100, 16'h7777, 1'b0);
        write(16'h0900, 16'hFFFF, 1'b0);   // R6 unimplemented: no effect

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (VEC[i].on_y) begin
                y_req = 1; y_addr = VEC[i].addr;
            end else begin
                x_req = 1; x_pref = VEC[i].pref; x_byte = VEC[i].byt; x_addr = VEC[i].addr;
            end
            @(negedge clk);
            if (VEC[i].on_y) begin
                check($sformatf("R9/R7 vec%0d y data", i), y_rdata, VEC[i].exp);
                check($sformatf("R2 vec%0d y flags", i), {14'b0, y_rvalid, y_invalid}, {14'b0, 1'b1, VEC[i].inv});
            end else begin
                check($sformatf("R3-8 vec%0d x data", i), x_rdata, VEC[i].exp);
                check($sformatf("R2 vec%0d x flags", i), {14'b0, x_rvalid, x_invalid}, {14'b0, 1'b1, VEC[i].inv});
            end
            idle_inputs();
        end

        // R2: concurrent X and Y reads
        @(negedge clk);
        x_req = 1; x_addr = 16'h0010; y_req = 1; y_addr = 16'h0500;
        @(negedge clk);
        idle_inputs();
        check("R2 concurrent x", x_rdata, 16'hAB34);
        check("R2 concurrent y", y_rdata, 16'hBEEF);
        check("R2 both valid", {14'b0, x_rvalid, y_rvalid}, 16'h0003);

        // R10: read during write sees old word, then new one
        @(negedge clk);
        x_req = 1; x_addr = 16'h0010;
        wr_en = 1; wr_addr = 16'h0010; wr_data = 16'h1111;
        @(negedge clk);
        wr_en = 0;
        check("R10 old", x_rdata, 16'hAB34);
        @(negedge clk);
        check("R10 new", x_rdata, 16'h1111);
        idle_inputs();
        @(negedge clk);
        check("R11 idle after", {14'b0, x_rvalid, x_invalid} | x_rdata, 16'h0000);
        check("R11 y idle", {14'b0, y_rvalid, y_invalid} | y_rdata, 16'h0000);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        x_req = 1; x_addr = 16'h0010;
        rst = 1;
        @(negedge clk);
        check("R1 reset during req", {14'b0, x_rvalid, x_invalid} | x_rdata, 16'h0000);
        rst = 0;
        idle_inputs();

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule